// File: doc/BRIEF.md
# Rotated Multi-Hit Priority Index Extractor

This block takes a 100-bit request vector and a 7-bit start offset. It reports the positions of up to ten set request bits, in priority order. The search begins at the offset and moves upward through the positions. After position 99 it wraps to position 0. In effect the vector is rotated cyclically by the offset, and the rotated copy is scanned from its lowest bit.

Each result is returned as a position in the original, unrotated vector. Each result also has a valid flag. A requester that holds the offset can therefore get fair, rotating service without converting indices itself.

The logic is purely combinational and has no clock or reset. The results follow the inputs within the same cycle. Any registering is left to whatever surrounds the block.

Top module: `mhp_rot_pick`

## Requirements
- R1: `hit_idx_o` packs ten 7-bit slot indices, with slot k in bits [7k+6:7k], and `hit_vld_o[k]` is the valid flag of slot k.
- R2: The scan visits original positions in the order s, s+1, ..., 99, 0, 1, ..., s-1, where s is the effective offset. Slot 0 holds the first set bit met in that order, slot 1 the second, and so on.
- R3: Every valid slot index is the hit's position in the unrotated request vector. No slot holds a position in the rotated frame.
- R4: An offset value from 100 to 127 is reduced modulo 100, so for example 103 acts exactly as 3 and 127 acts as 27.
- R5: The number of valid slots equals the lesser of ten and the number of set request bits. The valid slots are always slots 0 up to that count minus one.
- R6: Every slot that is not valid drives index 0. With an all-zero request vector, all ten valid flags are low and all indices are 0.
- R7: When more than ten request bits are set, only the first ten in scan order are reported. The remaining set bits have no effect on any output.
- R8: The outputs depend only on the present inputs. A change on the inputs shows at the outputs without any clock edge.
- R9: With offset 0, the valid indices appear in strictly ascending order of position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_i | input | 100 | Request vector, one bit per position |
| rot_i | input | 7 | Start offset of the search; values of 100 and above are reduced modulo 100 |
| hit_idx_o | output | 70 | Ten packed 7-bit hit positions, slot 0 in the low bits |
| hit_vld_o | output | 10 | Per-slot hit valid flags |

## Verification
The bench focuses on the wrap from position 99 to 0. An extractor that scanned linearly, or that forgot to add the offset back, would report the hits in the wrong order or as rotated-frame positions. Offsets of 100 and above are checked against their reduced values, because a design that skipped the reduction would index past the vector and return garbage or no hits. The bench also uses exactly ten, eleven and twelve set bits, and all-ones inputs. In these cases a slot chain that is off by one would drop a hit or report an eleventh one. The all-zero and sparse vectors catch unused slots that leak a stale index or raise a valid flag.

// File: rtl/mhp_pkg.sv
package mhp_pkg;

  // Addition of two positions on a ring of n entries; both inputs below n.
  function automatic int ring_add(input int a, input int b, input int n);
    int s;
    s = a + b;
    return (s >= n) ? s - n : s;
  endfunction

  // Folds an offset into 0..n-1; the offset range is below 2n.
  function automatic int fold_offset(input int a, input int n);
    return (a >= n) ? a - n : a;
  endfunction

endpackage

// File: rtl/mhp_rotate.sv
module mhp_rotate
  import mhp_pkg::*;
#(
  parameter int N  = 100,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] amt_i,
  output logic [N-1:0]  rot_o
);

  // rot_o[j] takes the request bit j positions after the start offset
  always_comb begin
    for (int j = 0; j < N; j++) begin
      logic [IW-1:0] src;
      src      = IW'(ring_add(j, int'(amt_i), N));
      rot_o[j] = req_i[src];
    end
  end

  // R4
  always_comb begin
    amt_in_range_chk: assert (int'(amt_i) < N)
      else $error("rotate offset out of range");
  end

endmodule

// File: rtl/mhp_first_set.sv
module mhp_first_set #(
  parameter int N  = 100,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] pos_o,
  output logic [N-1:0]  rest_o
);

  logic [N-1:0] lowest_oh;

  assign lowest_oh = vec_i & (~vec_i + N'(1));
  assign found_o   = |vec_i;
  assign rest_o    = vec_i & ~lowest_oh;

  always_comb begin
    pos_o = '0;
    for (int j = 0; j < N; j++) begin
      if (lowest_oh[j]) pos_o = pos_o | IW'(j);
    end
  end

  always_comb begin
    // R2
    lowest_hit_chk: assert (!found_o ||
                            (vec_i[pos_o] &&
                             ((vec_i & ((N'(1) << pos_o) - N'(1))) == '0)))
      else $error("reported position is not the lowest set bit");
    // R5
    one_cleared_chk: assert ($countones(rest_o) + (found_o ? 1 : 0) ==
                             $countones(vec_i))
      else $error("stage did not clear exactly one hit");
  end

endmodule

// File: rtl/mhp_slot_out.sv
module mhp_slot_out
  import mhp_pkg::*;
#(
  parameter int N  = 100,
  parameter int IW = $clog2(N)
) (
  input  logic          found_i,
  input  logic [IW-1:0] pos_i,
  input  logic [IW-1:0] amt_i,
  output logic [IW-1:0] idx_o,
  output logic          vld_o
);

  // Map the rotated-frame position back to the original frame
  assign idx_o = found_i ? IW'(ring_add(int'(pos_i), int'(amt_i), N)) : '0;
  assign vld_o = found_i;

  always_comb begin
    // R6
    idle_slot_zero_chk: assert (vld_o || idx_o == '0)
      else $error("invalid slot drives a nonzero index");
    // R3
    idx_in_range_chk: assert (int'(idx_o) < N)
      else $error("slot index outside the request vector");
  end

endmodule

// File: rtl/mhp_rot_pick.sv
module mhp_rot_pick
  import mhp_pkg::*;
#(
  parameter int N_REQ  = 100,
  parameter int N_SLOT = 10,
  parameter int ROT_W  = 7
) (
  input  logic [N_REQ-1:0]                 req_i,
  input  logic [ROT_W-1:0]                 rot_i,
  output logic [N_SLOT*$clog2(N_REQ)-1:0]  hit_idx_o,
  output logic [N_SLOT-1:0]                hit_vld_o
);

  localparam int IW = $clog2(N_REQ);

  // Named internal events for the assertions
  logic [IW-1:0]    amt_eff;
  logic [N_REQ-1:0] rot_vec;
  logic [N_REQ-1:0] stage_vec [N_SLOT+1];
  logic [N_SLOT-1:0] slot_found;
  logic [IW-1:0]    slot_pos [N_SLOT];

  // R4: offsets of N_REQ and above wrap once
  assign amt_eff = IW'(fold_offset(int'(rot_i), N_REQ));

  mhp_rotate #(.N(N_REQ), .IW(IW)) u_rot (
    .req_i (req_i),
    .amt_i (amt_eff),
    .rot_o (rot_vec)
  );

  assign stage_vec[0] = rot_vec;

  for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
    mhp_first_set #(.N(N_REQ), .IW(IW)) u_fs (
      .vec_i   (stage_vec[k]),
      .found_o (slot_found[k]),
      .pos_o   (slot_pos[k]),
      .rest_o  (stage_vec[k+1])
    );

    mhp_slot_out #(.N(N_REQ), .IW(IW)) u_out (
      .found_i (slot_found[k]),
      .pos_i   (slot_pos[k]),
      .amt_i   (amt_eff),
      .idx_o   (hit_idx_o[k*IW +: IW]),
      .vld_o   (hit_vld_o[k])
    );
  end

  always_comb begin
    // R5
    vld_thermo_chk: assert (((hit_vld_o + N_SLOT'(1)) & hit_vld_o) == '0)
      else $error("valid flags are not contiguous from slot 0");
    // R5
    vld_count_chk: assert ($countones(hit_vld_o) ==
                           (($countones(req_i) < N_SLOT) ? $countones(req_i) : N_SLOT))
      else $error("valid count differs from hit count");
    // R7
    leftover_chk: assert (slot_found[N_SLOT-1] || stage_vec[N_SLOT] == '0)
      else $error("hits left over while a slot is empty");
    // R2
    rising_pos_chk: assert (N_SLOT < 2 || !slot_found[1] || slot_pos[1] > slot_pos[0])
      else $error("rotated positions not in scan order");
  end

endmodule

// File: tb/sim_mhp_rot_pick.sv
`timescale 1ns/1ps
module sim_mhp_rot_pick;

  localparam int N  = 100;
  localparam int S  = 10;
  localparam int IW = 7;

  typedef struct {
    logic [N-1:0]    req;
    logic [IW-1:0]   rot;
    logic [S*IW-1:0] e_idx;
    logic [S-1:0]    e_vld;
    string           tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req;
  logic [IW-1:0]   rot;
  logic [S*IW-1:0] hit_idx;
  logic [S-1:0]    hit_vld;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;
  item_t sb[$];

  always #2 clk = ~clk;

  mhp_rot_pick u0 (
    .req_i     (req),
    .rot_i     (rot),
    .hit_idx_o (hit_idx),
    .hit_vld_o (hit_vld)
  );

  // Reference: walk original positions from the reduced offset, wrapping.
  task automatic ref_model(input logic [N-1:0] r, input logic [IW-1:0] o,
                           output logic [S*IW-1:0] ei, output logic [S-1:0] ev);
    int start;
    int cnt;
    ei    = '0;
    ev    = '0;
    cnt   = 0;
    start = int'(o) % N;
    for (int step = 0; step < N; step++) begin
      int p;
      p = (start + step) % N;
      if (r[p] && cnt < S) begin
        ei[cnt*IW +: IW] = IW'(p);
        ev[cnt] = 1'b1;
        cnt++;
      end
    end
  endtask

  task automatic compare(input string tag, input logic [S*IW-1:0] ei,
                         input logic [S-1:0] ev);
    checks++;
    if (hit_vld !== ev) begin
      errors++;
      $display("FAIL %s valid: actual %b expected %b", tag, hit_vld, ev);
    end
    checks++;
    if (hit_idx !== ei) begin
      errors++;
      $display("FAIL %s index: actual %h expected %h", tag, hit_idx, ei);
    end
  endtask

  // Driver: applies one stimulus per cycle and queues its expected result
  task automatic drive(input logic [N-1:0] r, input logic [IW-1:0] o, input string tag);
    item_t it;
    @(posedge clk);
    req = r;
    rot = o;
    it.req = r;
    it.rot = o;
    it.tag = tag;
    ref_model(r, o, it.e_idx, it.e_vld);
    sb.push_back(it);
  endtask

  // Monitor: compares the oldest queued item half a cycle after it was driven
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      compare(it.tag, it.e_idx, it.e_vld);
    end
  end

  function automatic logic [N-1:0] rnd_vec();
    logic [127:0] w;
    w = {$urandom, $urandom, $urandom, $urandom};
    return w[N-1:0];
  endfunction

  function automatic logic [N-1:0] bits_at(input int a, input int b, input int c, input int d);
    logic [N-1:0] v;
    v = '0;
    v[a] = 1'b1; v[b] = 1'b1; v[c] = 1'b1; v[d] = 1'b1;
    return v;
  endfunction

  function automatic logic [N-1:0] n_bits(input int n);
    logic [N-1:0] v;
    int placed;
    v = '0;
    placed = 0;
    while (placed < n) begin
      int p;
      p = $urandom_range(0, N-1);
      if (!v[p]) begin
        v[p] = 1'b1;
        placed++;
      end
    end
    return v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    logic [N-1:0] v;
    req = '0;
    rot = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R6: reset-time inputs of zero give an idle result
    drive('0, 7'd0,  "R6 all-zero offset 0");
    drive('0, 7'd57, "R6 all-zero offset 57");
    // R9 / R1: all ones from 0 gives 0..9 in packed order
    drive('1, 7'd0,  "R9 all-ones ascending");
    // R2 / R3: all ones wrapping past 99
    drive('1, 7'd95, "R2 all-ones wrap 95");
    // R2: wrap ordering on a small set
    drive(bits_at(98, 99, 0, 1), 7'd98, "R2 wrap order 98..1");
    drive(bits_at(98, 99, 0, 1), 7'd0,  "R9 ascending 0,1,98,99");
    drive(bits_at(98, 99, 0, 1), 7'd1,  "R3 start inside set");
    // R3: single hit at the top position
    v = '0; v[99] = 1'b1;
    drive(v, 7'd99, "R3 single at 99");
    drive(v, 7'd0,  "R3 single at 99 offset 0");
    // R4: offsets of 100 and above
    v = rnd_vec();
    drive(v, 7'd103, "R4 offset 103");
    drive(v, 7'd3,   "R4 offset 3");
    drive(v, 7'd127, "R4 offset 127");
    drive('1, 7'd100, "R4 offset 100");
    // R5 / R7: exactly ten, eleven, twelve set bits
    for (int i = 0; i < 10; i++) begin
      drive(n_bits(10), 7'($urandom_range(0, 127)), "R5 exactly ten");
      drive(n_bits(11), 7'($urandom_range(0, 127)), "R7 eleven set");
      drive(n_bits(12), 7'($urandom_range(0, 127)), "R7 twelve set");
    end
    // R5 / R6: sparse random
    for (int i = 0; i < 60; i++) begin
      drive(rnd_vec() & rnd_vec() & rnd_vec() & rnd_vec() & rnd_vec(),
            7'($urandom_range(0, 127)), "R5 sparse random");
    end
    // R2 / R3: dense random
    for (int i = 0; i < 150; i++) begin
      drive(rnd_vec(), 7'($urandom_range(0, 127)), "R2 dense random");
    end
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);

    // R8: change the inputs between edges and look before any edge
    @(negedge clk);
    #0.5;
    begin
      logic [S*IW-1:0] ei;
      logic [S-1:0]    ev;
      v = bits_at(5, 40, 77, 99);
      req = v;
      rot = 7'd41;
      ref_model(v, 7'd41, ei, ev);
      #0.5;
      compare("R8 no-clock response", ei, ev);
    end
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule